// File: doc/BRIEF.md
# Host Reset Supervisor with Bus-Kicked Watchdog

This block produces an active-low reset for a host processor. It holds the host in reset after power-up and while a low-supply indication is present. It also issues a fixed-length reset pulse when a watchdog runs out. The watchdog needs no dedicated service pin. It restarts whenever a start condition appears on a two-wire serial bus, meaning SDA falls while SCL is high. The supervisor watches the sampled SCL and SDA lines for that event and nothing else on the bus.

All timing counts pulses of a one-millisecond tick enable, so the clock frequency does not affect any period. The watchdog period comes from a 2-bit select input: three fixed lengths and an off setting. The low-supply input comes from an external analog comparator. While it is active, reset is held and a flag tells the bus logic to abandon any transfer in progress.

Top module: `rst_supervisor`

## Requirements
- R1: While the synchronous `rst` input is high, and on the first sample after it, `host_rst_n` is 0 and `bus_abort` is 0. Asserting `rst` during normal operation drives `host_rst_n` to 0 on the next cycle.
- R2: After `rst` is released, `host_rst_n` stays 0 until `vlow` has been 0 for PGOOD_MS consecutive ticks (default 250). Once released, it goes to 1.
- R3: The select codes give these watchdog periods, counted in ticks without any start condition: `wd_sel` = 2'b00 gives 1750, 2'b01 gives 750 and 2'b10 gives 250. When the period elapses, `host_rst_n` falls, exactly that many ticks after the watchdog was last loaded.
- R4: With `wd_sel` = 2'b11 the watchdog never expires, however long no start condition arrives.
- R5: A start condition reloads the watchdog with the full selected period. A start condition is SDA going from 1 to 0 while SCL is 1 in both sampled cycles, after a SYNC_STAGES-deep synchroniser. An SDA fall while SCL is 0 does not reload it.
- R6: A watchdog expiry holds `host_rst_n` at 0 for exactly PULSE_MS ticks (default 250).
- R7: A start condition that arrives during the watchdog reset pulse does not change the length of the pulse.
- R8: When `vlow` is 1 at a clock edge, `host_rst_n` is 0 and `bus_abort` is 1 after that edge. After `vlow` returns to 0, release requires PGOOD_MS fresh ticks.
- R9: After a watchdog pulse ends, the watchdog restarts from its full period.
- R10: A change of `wd_sel` while running reloads the watchdog with the newly selected period.
- R11: Periods advance only on cycles where `ms_tick` is 1. Without ticks, no expiry and no release happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ms_tick | input | 1 | One-cycle timebase enable, one per millisecond |
| vlow | input | 1 | Supply below trip point, active high |
| scl | input | 1 | Sampled serial clock line |
| sda | input | 1 | Sampled serial data line |
| wd_sel | input | 2 | Watchdog period select |
| host_rst_n | output | 1 | Registered active-low reset to the host |
| bus_abort | output | 1 | Registered request to terminate bus activity |

## Verification
A wrong tick count in the watchdog or pulse counter shows up as a changed number of high or low cycles on `host_rst_n`. With the tick running every second cycle, a one-tick error appears as a two-cycle difference, visible by the end of the first period after release. A stuck or spurious start detector shows as a reset that arrives early despite regular bus starts, or late after bogus SDA edges. A reset-state machine that misses `vlow` shows on the very next cycle as `host_rst_n` high or `bus_abort` low.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  typedef enum logic [1:0] {
    ST_PWR_WAIT = 2'd0,
    ST_RUN      = 2'd1,
    ST_WD_PULSE = 2'd2
  } rsup_state_t;

  localparam logic [1:0] SEL_LONG  = 2'b00;
  localparam logic [1:0] SEL_MID   = 2'b01;
  localparam logic [1:0] SEL_SHORT = 2'b10;
  localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/rsup_start_det.sv
module rsup_start_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o
);

  logic scl_s, sda_s;
  logic scl_prev, sda_prev;
  logic start_cond;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic scl_r, sda_r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_r <= 1'b1;
          sda_r <= 1'b1;
        end else begin
          scl_r <= scl_i;
          sda_r <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_r <= 1'b1;
          sda_r <= 1'b1;
        end else begin
          scl_r <= g_sync[g-1].scl_r;
          sda_r <= g_sync[g-1].sda_r;
        end
      end
    end
  end

  assign scl_s = g_sync[SYNC_STAGES-1].scl_r;
  assign sda_s = g_sync[SYNC_STAGES-1].sda_r;

  assign start_cond = scl_prev & scl_s & sda_prev & ~sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
      start_o  <= 1'b0;
    end else begin
      scl_prev <= scl_s;
      sda_prev <= sda_s;
      start_o  <= start_cond;
    end
  end

  // R5: a detected start follows an SDA fall seen with SCL high
  a_r5_start_needs_scl_high: assert property (@(posedge clk) disable iff (rst)
    start_o |-> ($past(scl_s) && !$past(sda_s)));

  // R5: a start is a single-cycle event
  a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog
  import rsup_pkg::*;
#(
  parameter int P_LONG  = 1750,
  parameter int P_MID   = 750,
  parameter int P_SHORT = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       run,
  input  logic       start,
  input  logic [1:0] sel,
  output logic       expire
);

  localparam int PMAX1 = (P_LONG > P_MID) ? P_LONG : P_MID;
  localparam int PMAX  = (PMAX1 > P_SHORT) ? PMAX1 : P_SHORT;
  localparam int CW    = $clog2(PMAX + 1);

  function automatic logic [CW-1:0] period_of(input logic [1:0] s);
    case (s)
      SEL_MID:   period_of = CW'(P_MID);
      SEL_SHORT: period_of = CW'(P_SHORT);
      default:   period_of = CW'(P_LONG);
    endcase
  endfunction

  logic [CW-1:0] left;
  logic [1:0]    sel_q;
  logic          sel_chg, enabled, reload;

  assign sel_chg = (sel != sel_q);
  assign enabled = (sel != SEL_OFF);
  assign reload  = !run || start || sel_chg;
  assign expire  = run && enabled && tick && !reload && (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= sel;
      left  <= period_of(sel);
    end else begin
      sel_q <= sel;
      if (reload)
        left <= period_of(sel);
      else if (tick && enabled && (left != '0))
        left <= left - CW'(1);
    end
  end

  // R5: a start while running loads the full period
  a_r5_start_reload: assert property (@(posedge clk) disable iff (rst)
    (run && start) |=> (left == $past(period_of(sel))));

  // R10: a change of select loads the new period
  a_r10_sel_reload: assert property (@(posedge clk) disable iff (rst)
    (run && sel_chg) |=> (left == $past(period_of(sel))));

  // R11: without a tick the remaining time holds
  a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (run && !tick && !start && !sel_chg) |=> $stable(left));

  // R3: the counter never exceeds the period it was loaded with
  a_r3_bounded: assert property (@(posedge clk) disable iff (rst)
    !sel_chg |-> (left <= period_of(sel_q)));

endmodule

// File: rtl/rsup_reset_gen.sv
module rsup_reset_gen
  import rsup_pkg::*;
#(
  parameter int PGOOD_TICKS = 250,
  parameter int PULSE_TICKS = 250
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic vlow,
  input  logic wd_expire,
  output logic run,
  output logic rst_n_o,
  output logic abort_o
);

  localparam int CMAX = (PGOOD_TICKS > PULSE_TICKS) ? PGOOD_TICKS : PULSE_TICKS;
  localparam int CW   = $clog2(CMAX + 1);

  rsup_state_t   state, nstate;
  logic [CW-1:0] cnt, ncnt;

  always_comb begin
    nstate = state;
    ncnt   = cnt;
    case (state)
      ST_PWR_WAIT: begin
        if (vlow) ncnt = '0;
        else if (tick) begin
          if (cnt == CW'(PGOOD_TICKS - 1)) begin
            nstate = ST_RUN;
            ncnt   = '0;
          end else ncnt = cnt + CW'(1);
        end
      end
      ST_RUN: begin
        if (vlow) begin
          nstate = ST_PWR_WAIT;
          ncnt   = '0;
        end else if (wd_expire) begin
          nstate = ST_WD_PULSE;
          ncnt   = '0;
        end
      end
      ST_WD_PULSE: begin
        if (vlow) begin
          nstate = ST_PWR_WAIT;
          ncnt   = '0;
        end else if (tick) begin
          if (cnt == CW'(PULSE_TICKS - 1)) begin
            nstate = ST_RUN;
            ncnt   = '0;
          end else ncnt = cnt + CW'(1);
        end
      end
      default: begin
        nstate = ST_PWR_WAIT;
        ncnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_PWR_WAIT;
      cnt     <= '0;
      rst_n_o <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      state   <= nstate;
      cnt     <= ncnt;
      rst_n_o <= (nstate == ST_RUN);
      abort_o <= vlow;
    end
  end

  assign run = (state == ST_RUN);

  // R8: low supply forces reset and abort on the next cycle
  a_r8_vlow_resets: assert property (@(posedge clk) disable iff (rst)
    vlow |=> (!rst_n_o && abort_o));

  // R2: release never happens while the supply is low
  a_r2_release_needs_good: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_o) |-> !$past(vlow));

  // R11: reset pulse and power wait end only on a tick
  a_r11_exit_on_tick: assert property (@(posedge clk) disable iff (rst)
    (state != ST_RUN && !tick) |=> !rst_n_o);

  // R6: the watchdog pulse is entered only from normal running
  a_r6_pulse_entry: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WD_PULSE && !$past(state == ST_WD_PULSE)) |-> $past(run));

  // R1: output matches the running state
  a_r1_out_matches_state: assert property (@(posedge clk) disable iff (rst)
    rst_n_o == run);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int P_LONG_MS   = 1750,
  parameter int P_MID_MS    = 750,
  parameter int P_SHORT_MS  = 250,
  parameter int PULSE_MS    = 250,
  parameter int PGOOD_MS    = 250,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick,
  input  logic       vlow,
  input  logic       scl,
  input  logic       sda,
  input  logic [1:0] wd_sel,
  output logic       host_rst_n,
  output logic       bus_abort
);

  logic start_evt;
  logic wd_run;
  logic wd_expire;

  rsup_start_det #(
    .SYNC_STAGES(SYNC_STAGES)
  ) i_start (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl),
    .sda_i   (sda),
    .start_o (start_evt)
  );

  rsup_watchdog #(
    .P_LONG  (P_LONG_MS),
    .P_MID   (P_MID_MS),
    .P_SHORT (P_SHORT_MS)
  ) i_wdog (
    .clk    (clk),
    .rst    (rst),
    .tick   (ms_tick),
    .run    (wd_run),
    .start  (start_evt),
    .sel    (wd_sel),
    .expire (wd_expire)
  );

  rsup_reset_gen #(
    .PGOOD_TICKS (PGOOD_MS),
    .PULSE_TICKS (PULSE_MS)
  ) i_rgen (
    .clk       (clk),
    .rst       (rst),
    .tick      (ms_tick),
    .vlow      (vlow),
    .wd_expire (wd_expire),
    .run       (wd_run),
    .rst_n_o   (host_rst_n),
    .abort_o   (bus_abort)
  );

  // R1: a synchronous reset drives the host reset low next cycle
  a_r1_rst_low: assert property (@(posedge clk)
    rst |=> !host_rst_n);

endmodule

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  localparam logic [1:0] VEC_SEL  [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         VEC_HIGH [NVEC] = '{3500, 1500, 500, -1};
  localparam int OFF_LIMIT = 4000;
  localparam int PULSE_CYC = 500;

  logic clk = 1'b0;
  logic rst, ms_tick, vlow, scl, sda;
  logic [1:0] wd_sel;
  logic host_rst_n, bus_abort;
  logic tick_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  initial ms_tick = 1'b0;
  always @(negedge clk) ms_tick <= tick_en ? ~ms_tick : 1'b0;

  rst_supervisor i_rst_supervisor (
    .clk        (clk),
    .rst        (rst),
    .ms_tick    (ms_tick),
    .vlow       (vlow),
    .scl        (scl),
    .sda        (sda),
    .wd_sel     (wd_sel),
    .host_rst_n (host_rst_n),
    .bus_abort  (bus_abort)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic count_level(input logic lvl, input int limit, output int n);
    n = 0;
    while (host_rst_n == lvl && n < limit) begin
      n++;
      step();
    end
  endtask

  task automatic kick();
    @(negedge clk); scl = 1'b1; sda = 1'b1;
    @(negedge clk); sda = 1'b0;
    repeat (3) @(negedge clk);
    scl = 1'b0;
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b1;
    step();
  endtask

  task automatic fake_start();
    @(negedge clk); scl = 1'b0;
    @(negedge clk); sda = 1'b0;
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b1;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int lost;
    rst = 1'b1; vlow = 1'b0; scl = 1'b1; sda = 1'b1; tick_en = 1'b1;
    wd_sel = VEC_SEL[0];
    repeat (5) step();
    chk("R1 reset host_rst_n", int'(host_rst_n), 0);
    chk("R1 reset bus_abort", int'(bus_abort), 0);

    @(negedge clk); rst = 1'b0;
    step();
    count_level(1'b0, 2000, n);
    chk_rng("R2 power-up hold cycles", n, 497, 502);

    // table walk over period selects; each pulse ends with the R9 restart
    for (int i = 0; i < NVEC; i++) begin
      if (VEC_HIGH[i] < 0) begin
        count_level(1'b1, OFF_LIMIT, n);
        chk("R4 disabled watchdog high cycles", n, OFF_LIMIT);
      end else begin
        count_level(1'b1, 5000, n);
        chk(i == 0 ? "R3 period sel00" : "R9 R3 full period after pulse", n, VEC_HIGH[i]);
        @(negedge clk); wd_sel = VEC_SEL[i+1];
        count_level(1'b0, 2000, n);
        chk("R6 pulse length", n, PULSE_CYC);
      end
    end

    // R10: leaving the off setting reloads with the new period
    @(negedge clk); wd_sel = 2'b10;
    step();
    count_level(1'b1, 5000, n);
    chk_rng("R10 reload on select change", n, 497, 502);
    count_level(1'b0, 2000, n);
    chk("R6 pulse after select change", n, PULSE_CYC);

    // R11: ticks stopped, nothing expires
    @(negedge clk); tick_en = 1'b0;
    count_level(1'b1, 2000, n);
    chk("R11 no expiry without ticks", n, 2000);
    @(negedge clk); tick_en = 1'b1;
    step();
    count_level(1'b1, 5000, n);
    chk_rng("R11 expiry resumes with ticks", n, 495, 503);
    count_level(1'b0, 2000, n);

    // R5: regular starts keep the host running
    lost = 0;
    for (int k = 0; k < 6; k++) begin
      kick();
      for (int c = 0; c < 300; c++) begin
        if (!host_rst_n) lost++;
        step();
      end
    end
    chk("R5 keep-alive low samples", lost, 0);
    kick();
    repeat (300) step();
    for (int k = 0; k < 3; k++) fake_start();
    count_level(1'b1, 5000, n);
    chk_rng("R5 SDA fall with SCL low ignored", n, 170, 200);

    // R7: starts during the pulse do not stretch it
    n = 0;
    fork
      count_level(1'b0, 2000, n);
      begin
        for (int k = 0; k < 4; k++) begin
          repeat (60) @(negedge clk);
          kick();
        end
      end
    join
    chk("R7 pulse with starts", n, PULSE_CYC);

    // R8: low supply
    repeat (100) step();
    @(negedge clk); vlow = 1'b1;
    step();
    chk("R8 vlow forces reset", int'(host_rst_n), 0);
    chk("R8 vlow raises abort", int'(bus_abort), 1);
    repeat (100) step();
    @(negedge clk); vlow = 1'b0;
    step();
    count_level(1'b0, 2000, n);
    chk_rng("R8 restart delay after vlow", n, 496, 502);
    chk("R8 abort clears", int'(bus_abort), 0);

    // R1: reset during operation
    repeat (20) step();
    @(negedge clk); rst = 1'b1;
    step();
    chk("R1 mid-run reset", int'(host_rst_n), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule